// File: doc/BRIEF.md
# Exception Entry Stack-Frame Sequencer

This block carries a processor from the moment an instruction classifier flags an exception to the moment the handler's first instruction is ready. It accepts one request at a time. A request carries a vector number, and the block also takes in the live status word, the address of the faulting instruction, the vector table base and the supervisor stack pointer. It copies the status word before it touches it. It then writes back a status word that has supervisor mode on and both trace bits off, so tracing stops while the handler runs.

Next it pushes a three-word frame onto the supervisor stack through a word-write memory port. It fetches the handler address from the vector table, points the fetch unit at that address and waits for the first prefetch to land. Only then does it signal that execution may resume and publish the new stack pointer.

The state machine runs ST_IDLE, ST_SAVE_SR, ST_PUSH_FMT, ST_PUSH_PC, ST_PUSH_SR, ST_READ_VEC, ST_PREFETCH, ST_DONE and back to ST_IDLE. Its transitions are:

- ST_IDLE to ST_SAVE_SR when a request is present.
- ST_SAVE_SR to ST_PUSH_FMT unconditionally.
- Each push state and ST_READ_VEC to the next state when `mem_ready` is high, and stay put otherwise.
- ST_PREFETCH to ST_DONE when `fetch_ready` is high.
- ST_DONE to ST_IDLE unconditionally.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, and after a reset taken in the middle of a sequence, `busy`, `mem_req`, `sr_we`, `fetch_redirect`, `done` and `ssp_we` are all 0.
- R2: A request is taken only in idle. While `busy` is 1, `req_valid` and the request fields are ignored, and the frame, status and vector read all use the values captured from the accepted request.
- R3: One cycle after acceptance, `sr_we` is 1 for exactly one cycle. `sr_out` equals the captured status word with bit 13 (supervisor) set, bits 15 and 14 (trace) cleared, and every other bit unchanged.
- R4: Three stack writes are made in this order, each with `mem_we`=1:
  - address SSP-4, data {16 zero bits, format nibble 0, 12-bit vector offset};
  - address SSP-8, data the fault PC;
  - address SSP-12, data the captured status word zero-extended.
  The status word therefore ends at the lowest address.
- R5: The stacked PC is the address of the faulting instruction exactly as presented, not a following address.
- R6: After the pushes, one read (`mem_we`=0) is issued at vector base + vector number × 4.
- R7: `fetch_redirect` is raised with `fetch_pc` equal to the word read in R6, and it holds until `fetch_ready`.
- R8: The cycle after `fetch_ready`, `done` and `ssp_we` pulse for one cycle with `ssp_out` = SSP-12. `busy` is 0 on the following cycle.
- R9: While a memory access waits (`mem_req`=1, `mem_ready`=0), `mem_addr`, `mem_wdata` and `mem_we` hold steady.
- R10: The vector offset is the vector number shifted left by 2, so vector 255 yields offset 1020 (0x3FC) in both the format word and the table read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Exception request from the classifier |
| req_vector | input | 8 | Vector number of the request |
| sr_in | input | 16 | Current status word |
| fault_pc | input | 32 | Address of the faulting instruction |
| vbr_in | input | 32 | Vector table base address |
| ssp_in | input | 32 | Supervisor stack pointer |
| busy | output | 1 | Sequencer is not idle; requests are held off |
| sr_we | output | 1 | Status word write strobe |
| sr_out | output | 16 | Modified status word |
| ssp_we | output | 1 | Stack pointer write strobe |
| ssp_out | output | 32 | Updated stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory access completes this cycle |
| mem_rdata | input | 32 | Memory read data |
| fetch_redirect | output | 1 | Redirect fetch to the handler |
| fetch_pc | output | 32 | Handler address |
| fetch_ready | input | 1 | First handler instruction prefetched |
| done | output | 1 | Exception entry complete, resume |

## Verification
The assertions check, on every cycle:
- that a memory access waiting on `mem_ready` keeps its address, data and direction;
- that a pending redirect keeps its target;
- that any status write carries supervisor-on and trace-off;
- that the write strobe, the completion pulse and the memory, redirect and status activities never overlap;
- that completion is always followed by idle.

Only the bench scenarios can show the frame contents and their order, the exact stack addresses, the table address and the immunity to a second request raised mid-sequence. These depend on values captured at acceptance and compared against expected values.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE_SR,
        ST_PUSH_FMT,
        ST_PUSH_PC,
        ST_PUSH_SR,
        ST_READ_VEC,
        ST_PREFETCH,
        ST_DONE
    } seq_state_e;

    // status word bit positions
    localparam int SR_T1_BIT = 15;
    localparam int SR_T0_BIT = 14;
    localparam int SR_S_BIT  = 13;

    // frame format nibble and offset field width of the first pushed word
    localparam logic [3:0] FRAME_FMT = 4'h0;
    localparam int         OFF_FIELD_W = 12;

endpackage

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
    import exc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       mem_ready,
    input  logic       fetch_ready,
    output seq_state_e state
);

    seq_state_e state_q;
    seq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid)   state_d = ST_SAVE_SR;
            ST_SAVE_SR:                   state_d = ST_PUSH_FMT;
            ST_PUSH_FMT: if (mem_ready)   state_d = ST_PUSH_PC;
            ST_PUSH_PC:  if (mem_ready)   state_d = ST_PUSH_SR;
            ST_PUSH_SR:  if (mem_ready)   state_d = ST_READ_VEC;
            ST_READ_VEC: if (mem_ready)   state_d = ST_PREFETCH;
            ST_PREFETCH: if (fetch_ready) state_d = ST_DONE;
            ST_DONE:                      state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/exc_seq_capture.sv
module exc_seq_capture
    import exc_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SR_W   = 16,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state,
    input  logic              req_valid,
    input  logic [VEC_W-1:0]  req_vector,
    input  logic [SR_W-1:0]   sr_in,
    input  logic [ADDR_W-1:0] fault_pc,
    input  logic [ADDR_W-1:0] vbr_in,
    input  logic [ADDR_W-1:0] ssp_in,
    input  logic              mem_ready,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic [VEC_W-1:0]  vec_q,
    output logic [SR_W-1:0]   sr_copy_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] vbr_q,
    output logic [ADDR_W-1:0] sp_q,
    output logic [ADDR_W-1:0] handler_q
);

    localparam int WORD_BYTES = ADDR_W / 8;

    logic accept;
    logic push_done;
    logic vec_done;

    assign accept    = (state == ST_IDLE) && req_valid;
    assign push_done = mem_ready &&
                       ((state == ST_PUSH_FMT) || (state == ST_PUSH_PC) ||
                        (state == ST_PUSH_SR));
    assign vec_done  = mem_ready && (state == ST_READ_VEC);

    // request snapshot, frozen for the whole sequence
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q     <= '0;
            sr_copy_q <= '0;
            pc_q      <= '0;
            vbr_q     <= '0;
        end else if (accept) begin
            vec_q     <= req_vector;
            sr_copy_q <= sr_in;
            pc_q      <= fault_pc;
            vbr_q     <= vbr_in;
        end
    end

    // working stack pointer, pre-decrement committed when a push completes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         sp_q <= '0;
        else if (accept)    sp_q <= ssp_in;
        else if (push_done) sp_q <= sp_q - ADDR_W'(WORD_BYTES);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        handler_q <= '0;
        else if (vec_done) handler_q <= mem_rdata;
    end

endmodule

// File: rtl/exc_seq_port.sv
module exc_seq_port
    import exc_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SR_W   = 16,
    parameter int VEC_W  = 8
) (
    input  seq_state_e        state,
    input  logic [VEC_W-1:0]  vec_q,
    input  logic [SR_W-1:0]   sr_copy_q,
    input  logic [ADDR_W-1:0] pc_q,
    input  logic [ADDR_W-1:0] vbr_q,
    input  logic [ADDR_W-1:0] sp_q,
    input  logic [ADDR_W-1:0] handler_q,
    output logic              busy,
    output logic              sr_we,
    output logic [SR_W-1:0]   sr_out,
    output logic              ssp_we,
    output logic [ADDR_W-1:0] ssp_out,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    output logic              fetch_redirect,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic              done
);

    localparam int WORD_BYTES = ADDR_W / 8;
    localparam int OFF_SHIFT  = $clog2(WORD_BYTES);
    localparam int OFF_PAD    = OFF_FIELD_W - VEC_W - OFF_SHIFT;
    localparam int FMT_PAD    = ADDR_W - 4 - OFF_FIELD_W;
    localparam int SR_PAD     = ADDR_W - SR_W;

    logic [OFF_FIELD_W-1:0] vec_off;
    logic [ADDR_W-1:0]      fmt_word;
    logic [ADDR_W-1:0]      sr_word;
    logic [ADDR_W-1:0]      sp_dec;
    logic [ADDR_W-1:0]      vec_addr;
    logic [SR_W-1:0]        sr_new;

    assign vec_off  = {{OFF_PAD{1'b0}}, vec_q, {OFF_SHIFT{1'b0}}};
    assign fmt_word = {{FMT_PAD{1'b0}}, FRAME_FMT, vec_off};
    assign sr_word  = {{SR_PAD{1'b0}}, sr_copy_q};
    assign sp_dec   = sp_q - ADDR_W'(WORD_BYTES);
    assign vec_addr = vbr_q + ADDR_W'(vec_off);

    always_comb begin
        sr_new            = sr_copy_q;
        sr_new[SR_S_BIT]  = 1'b1;
        sr_new[SR_T1_BIT] = 1'b0;
        sr_new[SR_T0_BIT] = 1'b0;
    end

    always_comb begin
        busy           = (state != ST_IDLE);
        sr_we          = 1'b0;
        sr_out         = sr_new;
        ssp_we         = 1'b0;
        ssp_out        = sp_q;
        mem_req        = 1'b0;
        mem_we         = 1'b0;
        mem_addr       = '0;
        mem_wdata      = '0;
        fetch_redirect = 1'b0;
        fetch_pc       = handler_q;
        done           = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_SAVE_SR: begin
                sr_we = 1'b1;
            end
            ST_PUSH_FMT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_dec;
                mem_wdata = fmt_word;
            end
            ST_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_dec;
                mem_wdata = pc_q;
            end
            ST_PUSH_SR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_dec;
                mem_wdata = sr_word;
            end
            ST_READ_VEC: begin
                mem_req  = 1'b1;
                mem_addr = vec_addr;
            end
            ST_PREFETCH: begin
                fetch_redirect = 1'b1;
            end
            ST_DONE: begin
                done   = 1'b1;
                ssp_we = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SR_W   = 16,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VEC_W-1:0]  req_vector,
    input  logic [SR_W-1:0]   sr_in,
    input  logic [ADDR_W-1:0] fault_pc,
    input  logic [ADDR_W-1:0] vbr_in,
    input  logic [ADDR_W-1:0] ssp_in,
    output logic              busy,
    output logic              sr_we,
    output logic [SR_W-1:0]   sr_out,
    output logic              ssp_we,
    output logic [ADDR_W-1:0] ssp_out,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              fetch_redirect,
    output logic [ADDR_W-1:0] fetch_pc,
    input  logic              fetch_ready,
    output logic              done
);

    seq_state_e        state;
    logic [VEC_W-1:0]  vec_q;
    logic [SR_W-1:0]   sr_copy_q;
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] vbr_q;
    logic [ADDR_W-1:0] sp_q;
    logic [ADDR_W-1:0] handler_q;

    exc_seq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .mem_ready   (mem_ready),
        .fetch_ready (fetch_ready),
        .state       (state)
    );

    exc_seq_capture #(
        .ADDR_W (ADDR_W),
        .SR_W   (SR_W),
        .VEC_W  (VEC_W)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .req_valid  (req_valid),
        .req_vector (req_vector),
        .sr_in      (sr_in),
        .fault_pc   (fault_pc),
        .vbr_in     (vbr_in),
        .ssp_in     (ssp_in),
        .mem_ready  (mem_ready),
        .mem_rdata  (mem_rdata),
        .vec_q      (vec_q),
        .sr_copy_q  (sr_copy_q),
        .pc_q       (pc_q),
        .vbr_q      (vbr_q),
        .sp_q       (sp_q),
        .handler_q  (handler_q)
    );

    exc_seq_port #(
        .ADDR_W (ADDR_W),
        .SR_W   (SR_W),
        .VEC_W  (VEC_W)
    ) u_port (
        .state          (state),
        .vec_q          (vec_q),
        .sr_copy_q      (sr_copy_q),
        .pc_q           (pc_q),
        .vbr_q          (vbr_q),
        .sp_q           (sp_q),
        .handler_q      (handler_q),
        .busy           (busy),
        .sr_we          (sr_we),
        .sr_out         (sr_out),
        .ssp_we         (ssp_we),
        .ssp_out        (ssp_out),
        .mem_req        (mem_req),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .fetch_redirect (fetch_redirect),
        .fetch_pc       (fetch_pc),
        .done           (done)
    );

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SR_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              sr_we,
    input logic [SR_W-1:0]   sr_out,
    input logic              ssp_we,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic              fetch_redirect,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              fetch_ready,
    input logic              done
);

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));

    // R7
    redirect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_redirect && !fetch_ready) |=> (fetch_redirect && $stable(fetch_pc)));

    // R3
    sr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we |-> (sr_out[SR_S_BIT] && !sr_out[SR_T1_BIT] && !sr_out[SR_T0_BIT]));

    // R3
    sr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we |=> !sr_we);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));

    // R8
    done_ssp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ssp_we);

    // R1
    exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, fetch_redirect, sr_we, done}));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_req || sr_we || fetch_redirect || done || ssp_we));

endmodule

bind exc_entry_seq exc_entry_chk #(
    .ADDR_W (ADDR_W),
    .SR_W   (SR_W)
) u_chk (.*);

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0]  vec;
        logic [15:0] sr;
        logic [31:0] pc;
        logic [31:0] vbr;
        logic [31:0] ssp;
        logic [3:0]  waits;
    } case_t;

    localparam int NCASES = 5;
    localparam case_t CASES [NCASES] = '{
        '{8'd4,   16'hC71F, 32'h0000_1234, 32'h0000_0000, 32'h0000_8000, 4'd0},
        '{8'd10,  16'h2700, 32'h0004_0A02, 32'h0010_0000, 32'h0002_0000, 4'd2},
        '{8'd255, 16'h8000, 32'hFFFF_FFFE, 32'h00FF_F000, 32'h0000_1000, 4'd1},
        '{8'd0,   16'h4000, 32'h0000_0000, 32'h8000_0000, 32'h0000_000C, 4'd3},
        '{8'd8,   16'hFFFF, 32'h1234_5678, 32'h0000_0400, 32'hFFFF_FFF0, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_vector = '0;
    logic [15:0] sr_in = '0;
    logic [31:0] fault_pc = '0;
    logic [31:0] vbr_in = '0;
    logic [31:0] ssp_in = '0;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        fetch_ready = 1'b0;
    logic        busy, sr_we, ssp_we, mem_req, mem_we, fetch_redirect, done;
    logic [15:0] sr_out;
    logic [31:0] ssp_out, mem_addr, mem_wdata, fetch_pc;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    exc_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
        .sr_in(sr_in), .fault_pc(fault_pc), .vbr_in(vbr_in), .ssp_in(ssp_in),
        .busy(busy), .sr_we(sr_we), .sr_out(sr_out), .ssp_we(ssp_we),
        .ssp_out(ssp_out), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .fetch_redirect(fetch_redirect), .fetch_pc(fetch_pc),
        .fetch_ready(fetch_ready), .done(done)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] handler_of(input logic [7:0] v);
        return 32'h0010_0000 + {22'd0, v, 2'b00} * 32'd16;
    endfunction

    // one memory access, held for 'waits' cycles before mem_ready
    task automatic mem_access(input string rq, input logic we,
                              input logic [31:0] addr, input logic [31:0] data,
                              input int waits);
        chk({rq, " mem_req"}, {31'd0, mem_req}, 32'd1);
        chk({rq, " mem_we"}, {31'd0, mem_we}, {31'd0, we});
        chk({rq, " addr"}, mem_addr, addr);
        if (we) chk({rq, " wdata"}, mem_wdata, data);
        for (int i = 0; i < waits; i++) begin
            tick();
            chk("R9 addr held", mem_addr, addr);
            if (we) chk("R9 wdata held", mem_wdata, data);
        end
        if (!we) mem_rdata = data;
        mem_ready = 1'b1;
        tick();
        mem_ready = 1'b0;
        mem_rdata = '0;
    endtask

    task automatic run_case(input case_t c);
        logic [15:0] exp_sr;
        logic [31:0] exp_fmt;
        exp_sr  = (c.sr | 16'h2000) & 16'h3FFF;
        exp_fmt = {16'h0, 4'h0, 2'b00, c.vec, 2'b00};
        req_valid = 1'b1; req_vector = c.vec; sr_in = c.sr;
        fault_pc = c.pc; vbr_in = c.vbr; ssp_in = c.ssp;
        tick();
        // R2: a second request with other values while busy
        req_vector = ~c.vec; sr_in = ~c.sr; fault_pc = c.pc + 32'd2;
        vbr_in = c.vbr + 32'h100; ssp_in = c.ssp - 32'h40;
        chk("R2 busy", {31'd0, busy}, 32'd1);
        chk("R3 sr_we", {31'd0, sr_we}, 32'd1);
        chk("R3 sr_out", {16'd0, sr_out}, {16'd0, exp_sr});
        tick();
        chk("R3 sr_we pulse", {31'd0, sr_we}, 32'd0);
        mem_access("R4 R10 fmt push", 1'b1, c.ssp - 32'd4, exp_fmt, c.waits);
        req_valid = 1'b0;
        mem_access("R4 R5 pc push", 1'b1, c.ssp - 32'd8, c.pc, c.waits);
        mem_access("R4 sr push", 1'b1, c.ssp - 32'd12, {16'd0, c.sr}, c.waits);
        mem_access("R6 R10 vector read", 1'b0, c.vbr + {22'd0, c.vec, 2'b00},
                   handler_of(c.vec), c.waits);
        chk("R7 redirect", {31'd0, fetch_redirect}, 32'd1);
        chk("R7 fetch_pc", fetch_pc, handler_of(c.vec));
        for (int i = 0; i < c.waits; i++) begin
            tick();
            chk("R7 redirect held", {31'd0, fetch_redirect}, 32'd1);
            chk("R8 no early done", {31'd0, done}, 32'd0);
        end
        fetch_ready = 1'b1;
        tick();
        fetch_ready = 1'b0;
        chk("R8 done", {31'd0, done}, 32'd1);
        chk("R8 ssp_we", {31'd0, ssp_we}, 32'd1);
        chk("R8 ssp_out", ssp_out, c.ssp - 32'd12);
        tick();
        chk("R8 idle after done", {30'd0, busy, done}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset outputs",
            {26'd0, busy, mem_req, sr_we, fetch_redirect, done, ssp_we}, 32'd0);
        rst_n = 1'b1;
        tick();
        chk("R1 idle after reset",
            {26'd0, busy, mem_req, sr_we, fetch_redirect, done, ssp_we}, 32'd0);

        for (int k = 0; k < NCASES; k++) run_case(CASES[k]);

        // R1: reset taken during the PC push
        req_valid = 1'b1; req_vector = 8'd9; sr_in = 16'h0000;
        fault_pc = 32'h0000_2000; vbr_in = '0; ssp_in = 32'h0000_4000;
        tick();
        req_valid = 1'b0;
        tick();
        mem_ready = 1'b1;
        tick();
        mem_ready = 1'b0;
        chk("R4 pc push addr before reset", mem_addr, 32'h0000_3FF8);
        rst_n = 1'b0;
        #1;
        chk("R1 mid-sequence reset",
            {26'd0, busy, mem_req, sr_we, fetch_redirect, done, ssp_we}, 32'd0);
        tick();
        rst_n = 1'b1;
        tick();
        run_case(CASES[1]);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule